// File: doc/BRIEF.md
# IPv6 Flow Result Cache

This block keeps the classification results of recently seen IPv6 flows, so that the full rule search runs only when a flow is not found. A lookup request carries the complete flow identifier: source address, destination address, source port, destination port and layer-4 protocol. The block picks a set by taking fixed bits of the source address. It computes a 32-bit tag by folding a compressed form of the identifier, and compares that tag against every way of the chosen set. One cycle later it reports either a hit with the stored result, or a miss.

After a miss, the external classifier computes the result and writes it back through a fill request. The fill takes an empty way of the set if one is free. Otherwise it replaces the way whose last access is oldest. A free-running timestamp is written into a way each time that way is hit or filled. Lookups and fills use separate ports and may arrive in the same cycle.

The flow identifier is 296 bits wide, with fields packed from the most significant end: source address [295:168], destination address [167:40], source port [39:24], destination port [23:8], protocol [7:0].

Top module: `fcache_top`

## Requirements
- R1: Before the tag is computed, the protocol byte is reduced to a 2-bit code: 58 (ICMPv6) gives 0, 6 (TCP) gives 1, 17 (UDP) gives 2, and every other value gives 3. Two flows that differ only in protocol values sharing a code are treated as the same flow.
- R2: Set index bit i is source-address bit (11*i mod 64), for i from 0 to log2(SETS)-1. With the default 64 sets, these are bits 0, 11, 22, 33, 44 and 55. Flows in different sets never evict each other.
- R3: A lookup hits only when a valid way in the selected set holds the flow's 32-bit tag. The tag is the XOR of the 32-bit chunks of the 290-bit compressed identifier after a fixed rotation. A flow that has never been filled misses.
- R4: A lookup accepted with lk_valid high in cycle t raises rsp_valid in cycle t+1 only. rsp_hit is never high while rsp_valid is low.
- R5: On a miss, rsp_hit is 0 and rsp_result is 0.
- R6: After a fill is accepted, a lookup of the same flow in any later cycle hits and returns the filled result, as long as the entry has not been evicted.
- R7: A fill of a flow that is not present takes the lowest-numbered invalid way of its set, so up to WAYS distinct flows of one set stay resident together.
- R8: When all ways are valid, a fill evicts the way with the smallest timestamp, with ties going to the lowest way. A hit refreshes the timestamp of that way.
- R9: A fill of a flow that is already present overwrites its result in place. It does not create a second copy and does not evict another way.
- R10: When a lookup and a fill happen in the same cycle, the lookup sees the contents and timestamps from before that cycle's fill, and the fill chooses its victim from those same pre-cycle timestamps. If the fill replaces the way the lookup hit, the fill wins.
- R11: Synchronous reset invalidates every entry and clears the response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_flow | input | 296 | Lookup flow identifier |
| fill_valid | input | 1 | Fill request valid |
| fill_flow | input | 296 | Flow identifier to install |
| fill_result | input | RES_W | Classification result to install |
| rsp_valid | output | 1 | Lookup response valid, one cycle after the request |
| rsp_hit | output | 1 | Lookup response hit |
| rsp_result | output | RES_W | Cached result on a hit, zero on a miss |

## Verification
A lookup and a fill can fall in the same clock cycle, and both may touch the same set. In that case the lookup's recency refresh and the fill's victim choice compete for one set's timestamps. The bench provokes this in two ways. First, it looks up a flow in the very cycle that flow is being filled, and expects a miss followed by a hit. Second, it fills a full set while hitting that set's oldest way. The expected outcome is that the hit response still carries the old result, that the oldest way is evicted by the fill, and that every other way stays resident.

// File: rtl/fcache_pkg.sv
package fcache_pkg;

    localparam int FLOW_W  = 296;
    localparam int CID_W   = 290;
    localparam int TAG_W   = 32;
    localparam int ROT_AMT = 13;
    localparam int CHUNKS  = (CID_W + TAG_W - 1) / TAG_W;
    localparam int IDX_MAX = 16;

    typedef struct packed {
        logic [127:0] src;
        logic [127:0] dst;
        logic [15:0]  sport;
        logic [15:0]  dport;
        logic [7:0]   proto;
    } flow_t;

    typedef enum logic [1:0] {
        PC_ICMP  = 2'd0,
        PC_TCP   = 2'd1,
        PC_UDP   = 2'd2,
        PC_OTHER = 2'd3
    } proto_code_e;

    function automatic proto_code_e squeeze_proto(input logic [7:0] p);
        case (p)
            8'd58:   return PC_ICMP;
            8'd6:    return PC_TCP;
            8'd17:   return PC_UDP;
            default: return PC_OTHER;
        endcase
    endfunction

    function automatic logic [CID_W-1:0] compress_flow(input flow_t f);
        return {f.src, f.dst, f.sport, f.dport, squeeze_proto(f.proto)};
    endfunction

    function automatic logic [IDX_MAX-1:0] pick_index(input logic [127:0] src);
        logic [IDX_MAX-1:0] idx;
        for (int i = 0; i < IDX_MAX; i++) begin
            idx[i] = src[(11 * i) % 64];
        end
        return idx;
    endfunction

    function automatic logic [TAG_W-1:0] fold_tag(input logic [CID_W-1:0] cid);
        logic [CHUNKS*TAG_W-1:0] wide;
        logic [CID_W-1:0]        rot;
        logic [TAG_W-1:0]        acc;
        rot  = (cid << ROT_AMT) | (cid >> (CID_W - ROT_AMT));
        wide = {{(CHUNKS*TAG_W-CID_W){1'b0}}, rot};
        acc  = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            acc ^= wide[c*TAG_W +: TAG_W];
        end
        return acc;
    endfunction

endpackage

// File: rtl/fcache_hash.sv
module fcache_hash
    import fcache_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [FLOW_W-1:0] flow,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    flow_t             f;
    logic [IDX_MAX-1:0] idx_full;

    always_comb begin
        f        = flow_t'(flow);
        idx_full = pick_index(f.src);
        idx      = idx_full[IDX_W-1:0];
        tag      = fold_tag(compress_flow(f));
    end
endmodule

// File: rtl/fcache_victim.sv
module fcache_victim #(
    parameter int WAYS  = 4,
    parameter int TS_W  = 16,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]           valid,
    input  logic [WAYS-1:0][TS_W-1:0] stamp,
    output logic [WAY_W-1:0]          way
);
    logic            found_free;
    logic [TS_W-1:0] oldest;

    always_comb begin
        found_free = 1'b0;
        way        = '0;
        oldest     = stamp[0];
        for (int w = 0; w < WAYS; w++) begin
            if (!valid[w] && !found_free) begin
                found_free = 1'b1;
                way        = WAY_W'(w);
            end
        end
        if (!found_free) begin
            for (int w = 1; w < WAYS; w++) begin
                if (stamp[w] < oldest) begin
                    oldest = stamp[w];
                    way    = WAY_W'(w);
                end
            end
        end
    end
endmodule

// File: rtl/fcache_top.sv
module fcache_top
    import fcache_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int RES_W = 16,
    parameter int TS_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [295:0]      lk_flow,
    input  logic              fill_valid,
    input  logic [295:0]      fill_flow,
    input  logic [RES_W-1:0]  fill_result,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [RES_W-1:0]  rsp_result
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [SETS-1:0][WAYS-1:0] vld_q;
    logic [TAG_W-1:0]          tag_q [SETS][WAYS];
    logic [RES_W-1:0]          res_q [SETS][WAYS];
    logic [TS_W-1:0]           ts_q  [SETS][WAYS];
    logic [TS_W-1:0]           tnow_q;

    logic [IDX_W-1:0] lk_idx, fl_idx;
    logic [TAG_W-1:0] lk_tag, fl_tag;

    fcache_hash #(.IDX_W(IDX_W)) u_hash_lk (
        .flow (lk_flow),
        .idx  (lk_idx),
        .tag  (lk_tag)
    );

    fcache_hash #(.IDX_W(IDX_W)) u_hash_fl (
        .flow (fill_flow),
        .idx  (fl_idx),
        .tag  (fl_tag)
    );

    logic [WAYS-1:0]           lk_hit_w, fl_match_w;
    logic [WAYS-1:0][TS_W-1:0] fl_stamp;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lk_hit_w[w]   = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
        assign fl_match_w[w] = vld_q[fl_idx][w] && (tag_q[fl_idx][w] == fl_tag);
        assign fl_stamp[w]   = ts_q[fl_idx][w];
    end

    logic [WAY_W-1:0] lk_way, match_way, victim_way, fl_way;
    logic             lk_any, fl_present;

    always_comb begin
        lk_way    = '0;
        match_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_hit_w[w])   lk_way    = WAY_W'(w);
            if (fl_match_w[w]) match_way = WAY_W'(w);
        end
        lk_any     = |lk_hit_w;
        fl_present = |fl_match_w;
    end

    fcache_victim #(.WAYS(WAYS), .TS_W(TS_W), .WAY_W(WAY_W)) u_victim (
        .valid (vld_q[fl_idx]),
        .stamp (fl_stamp),
        .way   (victim_way)
    );

    assign fl_way = fl_present ? match_way : victim_way;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q      <= '0;
            tnow_q     <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_result <= '0;
        end else begin
            tnow_q     <= tnow_q + 1'b1;
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_valid && lk_any;
            rsp_result <= (lk_valid && lk_any) ? res_q[lk_idx][lk_way] : '0;
            if (fill_valid) begin
                vld_q[fl_idx][fl_way] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (lk_valid && lk_any) begin
                ts_q[lk_idx][lk_way] <= tnow_q;
            end
            if (fill_valid) begin
                tag_q[fl_idx][fl_way] <= fl_tag;
                res_q[fl_idx][fl_way] <= fill_result;
                ts_q[fl_idx][fl_way]  <= tnow_q;
            end
        end
    end
endmodule

// File: rtl/fcache_chk.sv
module fcache_chk #(
    parameter int WAYS  = 4,
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic [295:0]     lk_flow,
    input logic             fill_valid,
    input logic [295:0]     fill_flow,
    input logic [RES_W-1:0] fill_result,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [RES_W-1:0] rsp_result,
    input logic [WAYS-1:0]  lk_hit_w
);
    a_r4_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    a_r4_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    a_r4_hit_within_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    a_r5_miss_result_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_result == '0));

    a_r9_single_copy: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit_w));

    a_r6_fill_then_hit: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fill_valid) && lk_valid && (lk_flow == $past(fill_flow)))
        |=> (rsp_hit && rsp_result == $past(fill_result, 2)));
endmodule

bind fcache_top fcache_chk #(.WAYS(WAYS), .RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_valid    (lk_valid),
    .lk_flow     (lk_flow),
    .fill_valid  (fill_valid),
    .fill_flow   (fill_flow),
    .fill_result (fill_result),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_result  (rsp_result),
    .lk_hit_w    (lk_hit_w)
);

// File: tb/test_fcache_top.sv
module test_fcache_top;
    localparam int RES_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             lk_valid = 1'b0;
    logic [295:0]     lk_flow = '0;
    logic             fill_valid = 1'b0;
    logic [295:0]     fill_flow = '0;
    logic [RES_W-1:0] fill_result = '0;
    logic             rsp_valid, rsp_hit;
    logic [RES_W-1:0] rsp_result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    fcache_top i_fcache_top (
        .clk         (clk),
        .rst         (rst),
        .lk_valid    (lk_valid),
        .lk_flow     (lk_flow),
        .fill_valid  (fill_valid),
        .fill_flow   (fill_flow),
        .fill_result (fill_result),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_result  (rsp_result)
    );

    // set bits go to source-address bits 0,11,22,33,44,55; id goes to the destination port
    function automatic logic [295:0] mk(input int set, input int id, input logic [7:0] proto);
        logic [127:0] src;
        src = 128'h2001_0db8_0000_0000_0000_0000_0000_0000;
        for (int i = 0; i < 6; i++) src[(11 * i) % 64] = set[i];
        return {src, 128'hfe80_0000_0000_0000_0000_0000_0000_0001,
                16'd4000, 16'(id), proto};
    endfunction

    function automatic logic [RES_W-1:0] rv(input int set, input int id);
        return RES_W'(set * 256 + id + 1);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [295:0] f, input logic [RES_W-1:0] r);
        @(negedge clk);
        fill_valid = 1'b1; fill_flow = f; fill_result = r;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_lookup(input string req, input logic [295:0] f,
                             input logic hit, input logic [RES_W-1:0] r);
        @(negedge clk);
        lk_valid = 1'b1; lk_flow = f;
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, {62'd0, rsp_valid, rsp_hit}, {62'd0, 1'b1, hit});
        check(req, 64'(rsp_result), hit ? 64'(r) : 64'd0);
    endtask

    task automatic t_reset_state;
        check("R11 reset rsp_valid", 64'(rsp_valid), 0);
        check("R11 reset rsp_hit", 64'(rsp_hit), 0);
    endtask

    task automatic t_timing_and_miss;
        @(negedge clk);
        lk_valid = 1'b1; lk_flow = mk(0, 1, 8'd6);
        @(negedge clk);
        lk_valid = 1'b0;
        check("R4 rsp one cycle later", 64'(rsp_valid), 1);
        check("R3 R5 unseen flow misses", {62'd0, rsp_hit, |rsp_result}, 0);
        @(negedge clk);
        check("R4 rsp only for one cycle", 64'(rsp_valid), 0);
    endtask

    task automatic t_fill_hit;
        do_fill(mk(1, 1, 8'd6), rv(1, 1));
        do_lookup("R6 filled flow hits", mk(1, 1, 8'd6), 1'b1, rv(1, 1));
        do_lookup("R3 other tag same set misses", mk(1, 2, 8'd6), 1'b0, '0);
    endtask

    task automatic t_proto;
        do_fill(mk(2, 1, 8'd50), rv(2, 1));
        do_lookup("R1 other protocols share code 3", mk(2, 1, 8'd51), 1'b1, rv(2, 1));
        do_lookup("R1 TCP differs from other", mk(2, 1, 8'd6), 1'b0, '0);
        do_fill(mk(2, 1, 8'd6), rv(2, 2));
        do_fill(mk(2, 1, 8'd17), rv(2, 3));
        do_lookup("R1 TCP entry", mk(2, 1, 8'd6), 1'b1, rv(2, 2));
        do_lookup("R1 UDP entry", mk(2, 1, 8'd17), 1'b1, rv(2, 3));
        do_lookup("R1 ICMPv6 not filled", mk(2, 1, 8'd58), 1'b0, '0);
    endtask

    task automatic t_sets;
        for (int s = 3; s < 8; s++) do_fill(mk(s, 9, 8'd6), rv(s, 9));
        for (int s = 3; s < 8; s++) do_lookup("R2 distinct sets keep entries", mk(s, 9, 8'd6), 1'b1, rv(s, 9));
    endtask

    task automatic t_free_ways;
        for (int i = 1; i <= 4; i++) do_fill(mk(10, i, 8'd6), rv(10, i));
        for (int i = 1; i <= 4; i++) do_lookup("R7 four flows resident", mk(10, i, 8'd6), 1'b1, rv(10, i));
    endtask

    task automatic t_lru;
        for (int i = 1; i <= 4; i++) do_fill(mk(11, i, 8'd6), rv(11, i));
        do_lookup("R8 refresh way of id1", mk(11, 1, 8'd6), 1'b1, rv(11, 1));
        do_fill(mk(11, 5, 8'd6), rv(11, 5));
        do_lookup("R8 oldest id2 evicted", mk(11, 2, 8'd6), 1'b0, '0);
        do_lookup("R8 refreshed id1 kept", mk(11, 1, 8'd6), 1'b1, rv(11, 1));
        do_lookup("R8 id3 kept", mk(11, 3, 8'd6), 1'b1, rv(11, 3));
        do_lookup("R8 id4 kept", mk(11, 4, 8'd6), 1'b1, rv(11, 4));
        do_lookup("R8 new id5 present", mk(11, 5, 8'd6), 1'b1, rv(11, 5));
    endtask

    task automatic t_refill;
        for (int i = 1; i <= 4; i++) do_fill(mk(12, i, 8'd6), rv(12, i));
        do_fill(mk(12, 2, 8'd6), 16'hbeef);
        do_lookup("R9 result overwritten", mk(12, 2, 8'd6), 1'b1, 16'hbeef);
        for (int i = 1; i <= 4; i++) begin
            if (i != 2) do_lookup("R9 no eviction on refill", mk(12, i, 8'd6), 1'b1, rv(12, i));
        end
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        lk_valid = 1'b1; lk_flow = mk(13, 1, 8'd6);
        fill_valid = 1'b1; fill_flow = mk(13, 1, 8'd6); fill_result = rv(13, 1);
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0;
        check("R10 lookup sees pre-fill state", {62'd0, rsp_valid, rsp_hit}, 64'd2);
        do_lookup("R10 fill visible next cycle", mk(13, 1, 8'd6), 1'b1, rv(13, 1));

        for (int i = 1; i <= 4; i++) do_fill(mk(14, i, 8'd6), rv(14, i));
        @(negedge clk);
        lk_valid = 1'b1; lk_flow = mk(14, 1, 8'd6);
        fill_valid = 1'b1; fill_flow = mk(14, 5, 8'd6); fill_result = rv(14, 5);
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0;
        check("R10 concurrent hit returns old result", {46'd0, rsp_hit, rsp_valid, rsp_result},
              {46'd0, 1'b1, 1'b1, rv(14, 1)});
        do_lookup("R10 oldest way lost to fill", mk(14, 1, 8'd6), 1'b0, '0);
        do_lookup("R10 filled flow present", mk(14, 5, 8'd6), 1'b1, rv(14, 5));
        for (int i = 2; i <= 4; i++) do_lookup("R10 others kept", mk(14, i, 8'd6), 1'b1, rv(14, i));
    endtask

    task automatic t_reset_clears;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_lookup("R11 entries cleared by reset", mk(1, 1, 8'd6), 1'b0, '0);
        do_lookup("R11 entries cleared by reset", mk(10, 3, 8'd6), 1'b0, '0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_timing_and_miss();
        t_fill_hit();
        t_proto();
        t_sets();
        t_free_ways();
        t_lru();
        t_refill();
        t_same_cycle();
        t_reset_clears();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule